// File: doc/BRIEF.md
# Named Wave Barrier Controller

This unit lets a group of concurrently running waves meet at a common point. It holds a small bank of numbered barriers and one workgroup barrier. Every wave sends its barrier operations, one per cycle across all waves, on a shared command port. The block answers with a one-cycle release pulse for each wave that may proceed, and a one-cycle completion pulse for each barrier that has just completed.

A numbered barrier keeps a member count and an arrival count. Its membership is dynamic. An explicit init or a signal that carries a non-zero count sets the member count. A leave lowers it, and the leave can itself complete the barrier. A wave must first bind itself to a barrier with a join before a wait can stall it on that barrier. The workgroup barrier needs no setup: the number of waves marked active in a mask is its member count.

Commands name a barrier through a 32-bit handle. Id 0 is the null barrier, which never synchronizes anything. Malformed commands set a sticky error flag and are otherwise dropped.

Top module: `wave_barrier_ctrl`

## Requirements
- R1: A handle is valid when it equals 0x0080_0000 in every bit outside bits [8:4]. Bits [8:4] hold the barrier id. Id 0 is the null barrier and ids 1 to 16 are numbered barriers. A handle that is invalid, or whose id is above 16, is an error when used by init, signal or join.
- R2: Init (cmd_op 0) loads cmd_count into the member count of the addressed barrier and clears its arrival count. It never raises a completion pulse.
- R3: Signal (cmd_op 1) with cmd_count 0 adds one arrival. When the arrivals reach the member count, bar_done[id] pulses for one cycle, starting the cycle after the command. A signal to a barrier whose member count is 0 has no effect.
- R4: Signal with a non-zero cmd_count first loads that count as the member count, then counts its own arrival. It can therefore complete the barrier at once.
- R5: On completion the arrival count returns to zero. The same barrier can then complete again in a later phase without a new init.
- R6: Join (cmd_op 2) records the handle's barrier as the wave's joined barrier. It clears any pending completion and any stall of that wave. It does not change a member count.
- R7: Leave (cmd_op 3) decrements the member count of the wave's joined barrier, stopping at 0. If at least one arrival is recorded and the arrivals are at or above the reduced count, the barrier completes. The wave's joined barrier then becomes null. A leave while the joined barrier is already null changes no count.
- R8: Wait (cmd_op 4) stalls the wave until its joined barrier completes. The wave's wave_release bit then pulses the cycle after the completing command. If the barrier completed after the join and before the wait, the pulse comes the cycle after the wait.
- R9: Workgroup sync (cmd_op 5) counts an arrival at the workgroup barrier. When the arrivals reach the number of set bits in active_mask, every stalled workgroup wave and the issuing wave are released, bar_done[0] pulses, and the count returns to zero.
- R10: Init or signal that addresses the null barrier has no effect, and raises no error and no pulse.
- R11: The following commands set err_flag and are otherwise ignored: a wait while the wave's joined barrier is null, and the invalid handles of R1. err_flag stays set until reset. cmd_op 6 and 7 are ignored without error.
- R12: After reset all counts, joins, stalls and pending completions are clear, and wave_release, bar_done and err_flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| active_mask | input | NW | Waves counted as workgroup members |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_wave | input | WW | Issuing wave index |
| cmd_handle | input | 32 | Barrier handle |
| cmd_count | input | CW | Member count for init or signal |
| wave_release | output | NW | One-cycle release pulse per wave |
| bar_done | output | NB+1 | One-cycle completion pulse; bit 0 is the workgroup barrier |
| err_flag | output | 1 | Sticky error flag |

## Verification
A command is taken at a rising edge. All three outputs are registered, so a release, completion or error caused by that command appears in the cycle after that edge, and a release pulse lasts exactly one cycle. The bench drives each command on a falling edge, holds it through one rising edge, and compares all outputs at the next falling edge, which falls inside that one-cycle window. A pending release that is consumed by a later wait is due one cycle after the wait, not after the signal that completed the barrier.

// File: rtl/wbar_pkg.sv
package wbar_pkg;
  typedef enum logic [2:0] {
    OP_INIT    = 3'd0,
    OP_SIGNAL  = 3'd1,
    OP_JOIN    = 3'd2,
    OP_LEAVE   = 3'd3,
    OP_WAIT    = 3'd4,
    OP_WG_SYNC = 3'd5
  } wbar_op_e;

  localparam logic [31:0] WBAR_HANDLE_BASE = 32'h0080_0000;
  localparam int          WBAR_ID_LSB      = 4;
endpackage

// File: rtl/wbar_decode.sv
module wbar_decode
  import wbar_pkg::*;
#(
  parameter int NB  = 16,
  parameter int IDW = 5
) (
  input  logic [31:0]    handle,
  output logic [IDW-1:0] id,
  output logic           bad
);
  localparam logic [31:0] FIELD_MASK = ((32'd1 << IDW) - 32'd1) << WBAR_ID_LSB;

  always_comb begin
    id  = handle[WBAR_ID_LSB +: IDW];
    bad = ((handle & ~FIELD_MASK) != WBAR_HANDLE_BASE) || (32'(id) > NB);
  end
endmodule

// File: rtl/wbar_bank.sv
module wbar_bank #(
  parameter int NB  = 16,
  parameter int IDW = 5,
  parameter int CW  = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           do_init,
  input  logic           do_sig,
  input  logic           do_leave,
  input  logic [IDW-1:0] tgt,
  input  logic [CW-1:0]  count,
  output logic           fire
);
  logic [CW-1:0]  mem_q [NB+1];
  logic [CW-1:0]  arr_q [NB+1];
  logic [IDW-1:0] idx;
  logic [CW-1:0]  cur_mem, cur_arr, nxt_mem, nxt_arr, inc_arr;
  logic           wr;

  always_comb begin
    idx     = (32'(tgt) > NB) ? '0 : tgt;
    cur_mem = mem_q[idx];
    cur_arr = arr_q[idx];
    inc_arr = cur_arr + 1'b1;
    nxt_mem = cur_mem;
    nxt_arr = cur_arr;
    fire    = 1'b0;
    wr      = 1'b0;
    if (do_init) begin
      nxt_mem = count;
      nxt_arr = '0;
      wr      = 1'b1;
    end else if (do_sig) begin
      if (count != '0) nxt_mem = count;
      if (nxt_mem != '0) begin
        wr = 1'b1;
        if (inc_arr >= nxt_mem) begin
          fire    = 1'b1;
          nxt_arr = '0;
        end else begin
          nxt_arr = inc_arr;
        end
      end
    end else if (do_leave) begin
      wr = 1'b1;
      if (cur_mem != '0) nxt_mem = cur_mem - 1'b1;
      if ((cur_arr != '0) && (cur_arr >= nxt_mem)) begin
        fire    = 1'b1;
        nxt_arr = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= NB; i++) begin
        mem_q[i] <= '0;
        arr_q[i] <= '0;
      end
    end else if (wr && (idx != '0)) begin
      mem_q[idx] <= nxt_mem;
      arr_q[idx] <= nxt_arr;
    end
  end
endmodule

// File: rtl/wbar_wave.sv
module wbar_wave #(
  parameter int NW  = 8,
  parameter int WW  = 3,
  parameter int IDW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           do_join,
  input  logic           do_leave,
  input  logic           do_wait,
  input  logic           do_wg,
  input  logic [WW-1:0]  wave,
  input  logic [IDW-1:0] join_id,
  input  logic           named_fire,
  input  logic [IDW-1:0] fire_id,
  input  logic           wg_fire,
  output logic [IDW-1:0] joined_sel,
  output logic [NW-1:0]  rel_o
);
  logic [IDW-1:0] joined_a [NW];

  assign joined_sel = (32'(wave) < NW) ? joined_a[wave] : '0;

  for (genvar w = 0; w < NW; w++) begin : g_wave
    logic [IDW-1:0] joined_r;
    logic           waitn_r, waitwg_r, done_r, rel_r;
    logic           sel;

    assign sel = (32'(wave) == w);

    always_ff @(posedge clk) begin
      if (rst) begin
        joined_r <= '0;
        waitn_r  <= 1'b0;
        waitwg_r <= 1'b0;
        done_r   <= 1'b0;
        rel_r    <= 1'b0;
      end else begin
        rel_r <= 1'b0;
        if (named_fire && (joined_r == fire_id)) begin
          if (waitn_r) begin
            rel_r   <= 1'b1;
            waitn_r <= 1'b0;
          end else begin
            done_r <= 1'b1;
          end
        end
        if (wg_fire && waitwg_r) begin
          rel_r    <= 1'b1;
          waitwg_r <= 1'b0;
        end
        if (sel) begin
          if (do_join) begin
            joined_r <= join_id;
            done_r   <= 1'b0;
            waitn_r  <= 1'b0;
          end
          if (do_leave) begin
            joined_r <= '0;
            done_r   <= 1'b0;
            waitn_r  <= 1'b0;
          end
          if (do_wait) begin
            if (done_r) begin
              rel_r  <= 1'b1;
              done_r <= 1'b0;
            end else begin
              waitn_r <= 1'b1;
            end
          end
          if (do_wg) begin
            if (wg_fire) rel_r <= 1'b1;
            else         waitwg_r <= 1'b1;
          end
        end
      end
    end

    assign rel_o[w]    = rel_r;
    assign joined_a[w] = joined_r;
  end
endmodule

// File: rtl/wave_barrier_ctrl.sv
module wave_barrier_ctrl
  import wbar_pkg::*;
#(
  parameter  int NW  = 8,
  parameter  int NB  = 16,
  localparam int WW  = (NW > 1) ? $clog2(NW) : 1,
  localparam int CW  = $clog2(NW + 1),
  localparam int IDW = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] active_mask,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [WW-1:0] cmd_wave,
  input  logic [31:0]   cmd_handle,
  input  logic [CW-1:0] cmd_count,
  output logic [NW-1:0] wave_release,
  output logic [NB:0]   bar_done,
  output logic          err_flag
);
  logic [IDW-1:0] dec_id, joined_sel, tgt;
  logic           dec_bad, wave_ok, needs_handle, err_now, good;
  logic           do_init, do_sig, do_join, do_leave, do_wait, do_wg, bank_leave;
  logic           named_fire, wg_fire;
  logic [CW-1:0]  wg_cnt_q;
  logic [NB:0]    done_d;
  logic [NB:0]    done_q;
  logic           err_q;

  wbar_decode #(.NB(NB), .IDW(IDW)) u_dec (
    .handle(cmd_handle), .id(dec_id), .bad(dec_bad)
  );

  always_comb begin
    wave_ok      = (32'(cmd_wave) < NW);
    needs_handle = (cmd_op == OP_INIT) || (cmd_op == OP_SIGNAL) || (cmd_op == OP_JOIN);
    err_now      = cmd_valid && (!wave_ok || (needs_handle && dec_bad) ||
                                 ((cmd_op == OP_WAIT) && (joined_sel == '0)));
    good         = cmd_valid && !err_now;
    do_init      = good && (cmd_op == OP_INIT)   && (dec_id != '0);
    do_sig       = good && (cmd_op == OP_SIGNAL) && (dec_id != '0);
    do_join      = good && (cmd_op == OP_JOIN);
    do_leave     = good && (cmd_op == OP_LEAVE);
    bank_leave   = do_leave && (joined_sel != '0);
    do_wait      = good && (cmd_op == OP_WAIT);
    do_wg        = good && (cmd_op == OP_WG_SYNC);
    tgt          = (cmd_op == OP_LEAVE) ? joined_sel : dec_id;
    wg_fire      = do_wg && ((32'(wg_cnt_q) + 32'd1) >= 32'($countones(active_mask)));
  end

  wbar_bank #(.NB(NB), .IDW(IDW), .CW(CW)) u_bank (
    .clk(clk), .rst(rst), .do_init(do_init), .do_sig(do_sig), .do_leave(bank_leave),
    .tgt(tgt), .count(cmd_count), .fire(named_fire)
  );

  wbar_wave #(.NW(NW), .WW(WW), .IDW(IDW)) u_wave (
    .clk(clk), .rst(rst), .do_join(do_join), .do_leave(do_leave), .do_wait(do_wait),
    .do_wg(do_wg), .wave(cmd_wave), .join_id(dec_id), .named_fire(named_fire),
    .fire_id(tgt), .wg_fire(wg_fire), .joined_sel(joined_sel), .rel_o(wave_release)
  );

  always_comb begin
    for (int b = 0; b <= NB; b++) done_d[b] = named_fire && (32'(tgt) == b);
    done_d[0] = wg_fire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wg_cnt_q <= '0;
      done_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      done_q <= done_d;
      if (err_now) err_q <= 1'b1;
      if (do_wg) wg_cnt_q <= wg_fire ? '0 : wg_cnt_q + 1'b1;
    end
  end

  assign bar_done = done_q;
  assign err_flag = err_q;
endmodule

// File: rtl/wbar_checker.sv
module wbar_checker
  import wbar_pkg::*;
#(
  parameter int NW = 8,
  parameter int NB = 16,
  parameter int WW = 3,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic [31:0]   cmd_handle,
  input logic [NW-1:0] wave_release,
  input logic [NB:0]   bar_done,
  input logic          err_flag
);
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  a_r3_single_done: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bar_done));

  a_r8_release_has_cause: assert property (@(posedge clk) disable iff (rst)
    (wave_release != '0) |-> $past(cmd_valid));

  a_r9_wg_done_cause: assert property (@(posedge clk) disable iff (rst)
    bar_done[0] |-> $past(cmd_valid && (cmd_op == OP_WG_SYNC)));

  a_r2_init_no_done: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_op == OP_INIT)) |=> (bar_done == '0));

  a_r1_bad_base_err: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_op == OP_INIT) && (cmd_handle[31:24] != 8'h00)) |=> err_flag);
endmodule

bind wave_barrier_ctrl wbar_checker #(.NW(NW), .NB(NB), .WW(WW), .CW(CW)) u_wbar_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_handle(cmd_handle),
  .wave_release(wave_release), .bar_done(bar_done), .err_flag(err_flag)
);

// File: tb/test_wave_barrier_ctrl.sv
module test_wave_barrier_ctrl;
  import wbar_pkg::*;

  localparam int NW = 8;
  localparam int NB = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  active_mask = 8'hFF;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [2:0]  cmd_wave = '0;
  logic [31:0] cmd_handle = '0;
  logic [3:0]  cmd_count = '0;
  logic [7:0]  wave_release;
  logic [16:0] bar_done;
  logic        err_flag;

  int n_chk = 0;
  int n_fail = 0;

  int mm [17];
  int ma [17];
  int mj [8];
  bit mwn [8];
  bit md [8];
  bit mww [8];
  int mwg;
  bit merr;
  logic [7:0]  erel;
  logic [16:0] edone;

  always #2 clk = ~clk;

  wave_barrier_ctrl #(.NW(NW), .NB(NB)) i_wave_barrier_ctrl (
    .clk(clk), .rst(rst), .active_mask(active_mask), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_wave(cmd_wave), .cmd_handle(cmd_handle), .cmd_count(cmd_count),
    .wave_release(wave_release), .bar_done(bar_done), .err_flag(err_flag)
  );

  function automatic logic [31:0] hnd(input int id);
    return 32'h0080_0000 | (32'(id) << 4);
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag,
                     input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < 17; i++) begin mm[i] = 0; ma[i] = 0; end
    for (int i = 0; i < 8; i++) begin mj[i] = 0; mwn[i] = 0; md[i] = 0; mww[i] = 0; end
    mwg = 0; merr = 0;
  endtask

  task automatic m_complete(input int b);
    edone[b] = 1'b1;
    ma[b] = 0;
    for (int v = 0; v < 8; v++) begin
      if (mj[v] == b) begin
        if (mwn[v]) begin erel[v] = 1'b1; mwn[v] = 0; end
        else md[v] = 1;
      end
    end
  endtask

  task automatic m_apply(input int op, input int w, input logic [31:0] h, input int cnt);
    int  id, jw, nm;
    bit  bad, needh;
    erel = '0; edone = '0;
    id    = int'(h[8:4]);
    bad   = ((h & ~32'h0000_01F0) != 32'h0080_0000) || (id > 16);
    needh = (op == 0) || (op == 1) || (op == 2);
    jw    = mj[w];
    if ((needh && bad) || (op == 4 && jw == 0)) begin
      merr = 1;
    end else begin
      case (op)
        0: if (id != 0) begin mm[id] = cnt; ma[id] = 0; end
        1: if (id != 0) begin
             nm = (cnt != 0) ? cnt : mm[id];
             if (nm != 0) begin
               mm[id] = nm;
               if (ma[id] + 1 >= nm) m_complete(id);
               else ma[id] = ma[id] + 1;
             end
           end
        2: begin mj[w] = id; md[w] = 0; mwn[w] = 0; end
        3: begin
             if (jw != 0) begin
               if (mm[jw] > 0) mm[jw] = mm[jw] - 1;
               if (ma[jw] != 0 && ma[jw] >= mm[jw]) m_complete(jw);
             end
             mj[w] = 0; md[w] = 0; mwn[w] = 0;
           end
        4: if (md[w]) begin erel[w] = 1'b1; md[w] = 0; end
           else mwn[w] = 1;
        5: if (mwg + 1 >= $countones(active_mask)) begin
             edone[0] = 1'b1;
             for (int v = 0; v < 8; v++)
               if (mww[v]) begin erel[v] = 1'b1; mww[v] = 0; end
             erel[w] = 1'b1;
             mwg = 0;
           end else begin
             mww[w] = 1;
             mwg = mwg + 1;
           end
        default: ;
      endcase
    end
  endtask

  task automatic issue(input int op, input int w, input logic [31:0] h, input int cnt,
                       input string tag);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_wave = 3'(w); cmd_handle = h; cmd_count = 4'(cnt);
    m_apply(op, w, h, cnt);
    @(posedge clk);
    @(negedge clk);
    chk(32'(wave_release), 32'(erel), tag, "wave_release");
    chk(32'(bar_done), 32'(edone), tag, "bar_done");
    chk(32'(err_flag), 32'(merr), tag, "err_flag");
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; cmd_valid = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_reset();
    @(negedge clk);
    chk(32'(wave_release), 32'd0, "R12", "reset release");
    chk(32'(bar_done), 32'd0, "R12", "reset done");
    chk(32'(err_flag), 32'd0, "R12", "reset err");
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    do_reset();

    // R2 R6 R3 R8: two members, one waits, the other completes
    issue(0, 0, hnd(3), 2, "R2");
    issue(2, 0, hnd(3), 0, "R6");
    issue(2, 1, hnd(3), 0, "R6");
    issue(1, 0, hnd(3), 0, "R3");
    issue(4, 0, 32'h0, 0, "R8");
    chk(32'(wave_release), 32'd0, "R8", "stalled wave");
    issue(1, 1, hnd(3), 0, "R3");
    chk(32'(bar_done), 32'h8, "R3", "completion bit 3");
    chk(32'(wave_release), 32'h1, "R8", "release of waiter");
    issue(4, 1, 32'h0, 0, "R8");
    chk(32'(wave_release), 32'h2, "R8", "pending completion consumed");
    // R5: reuse without init
    issue(1, 0, hnd(3), 0, "R5");
    issue(1, 1, hnd(3), 0, "R5");
    chk(32'(bar_done), 32'h8, "R5", "second phase");
    // R4: initializing signal completes at once
    issue(2, 2, hnd(5), 0, "R6");
    issue(1, 2, hnd(5), 1, "R4");
    chk(32'(bar_done), 32'h20, "R4", "initializing signal");
    issue(4, 2, 32'h0, 0, "R4");
    // R7: leave completes
    issue(0, 0, hnd(7), 3, "R2");
    issue(2, 3, hnd(7), 0, "R7");
    issue(2, 4, hnd(7), 0, "R7");
    issue(2, 5, hnd(7), 0, "R7");
    issue(1, 3, hnd(7), 0, "R7");
    issue(1, 4, hnd(7), 0, "R7");
    issue(4, 3, 32'h0, 0, "R7");
    issue(3, 5, 32'h0, 0, "R7");
    chk(32'(bar_done), 32'h80, "R7", "leave completion");
    chk(32'(wave_release), 32'h8, "R7", "leave releases waiter");
    issue(4, 5, 32'h0, 0, "R11");
    chk(32'(err_flag), 32'd1, "R11", "wait on null");

    // R10: null barrier
    do_reset();
    issue(1, 0, hnd(0), 2, "R10");
    issue(0, 0, hnd(0), 2, "R10");
    issue(2, 0, hnd(0), 0, "R10");
    issue(3, 0, 32'h0, 0, "R10");
    chk(32'(err_flag), 32'd0, "R10", "no error on null");

    // R1: handle decode
    do_reset();
    issue(0, 1, 32'h0080_0008, 2, "R1");
    chk(32'(err_flag), 32'd1, "R1", "low bits set");
    do_reset();
    issue(0, 1, hnd(17), 2, "R1");
    chk(32'(err_flag), 32'd1, "R1", "id 17");
    do_reset();
    issue(0, 1, 32'h0180_0010, 2, "R1");
    issue(6, 1, 32'h0, 0, "R11");
    chk(32'(err_flag), 32'd1, "R11", "sticky");

    // R9: workgroup barrier with four active waves
    do_reset();
    active_mask = 8'h0F;
    issue(5, 0, 32'h0, 0, "R9");
    issue(5, 1, 32'h0, 0, "R9");
    issue(5, 2, 32'h0, 0, "R9");
    chk(32'(wave_release), 32'd0, "R9", "not yet");
    issue(5, 3, 32'h0, 0, "R9");
    chk(32'(wave_release), 32'h0F, "R9", "all released");
    chk(32'(bar_done), 32'h1, "R9", "workgroup completion");
    active_mask = 8'hFF;

    // random mix
    for (int k = 0; k < 2400; k++) begin
      int op, w, id, cnt;
      logic [31:0] h;
      if (k % 300 == 0) do_reset();
      op  = int'($urandom % 7);
      w   = int'($urandom % 8);
      id  = int'($urandom % 18);
      cnt = (($urandom % 4) == 0) ? int'($urandom % 9) : 0;
      h   = (($urandom % 40) == 0) ? 32'h0090_0000 : hnd(id);
      issue(op, w, h, cnt, "RND");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule